// File: doc/BRIEF.md
# Packed-Word Audio Sample Unpacker

The block takes 64-bit words from an audio sample FIFO and breaks them into single samples for a serial audio transmitter. A type code sets the container width inside each word: eight 8-bit, four 16-bit or two 32-bit slots. Each sample sits right-justified in its slot. The slots are consumed from the least significant end of the word upward.

A 5-bit MSB index gives the true sample width minus one. Every sample is realigned so its top bit lands on bit 23 of a 24-bit output, and the bits below it are zero-filled. A channel mask chooses stereo or mono. In stereo, consecutive samples go out on channel A and then channel B. In mono, each sample goes out twice, first tagged A and then tagged B.

The word input and the sample output both use valid/ready handshakes. A new word is accepted only after every output of the word currently held has been taken.

Top module: `sample_unpacker`

## Requirements
- R1: While reset is asserted and right after it is released, `smp_valid_o` is 0 and `word_ready_o` is 1.
- R2: Type code 0 splits a word into eight 8-bit slots, slot k being bits [8k+7:8k], and emits them from slot 0 up to slot 7.
- R3: Type code 2 splits a word into four 16-bit slots, slot k being bits [16k+15:16k], and emits them from slot 0 up to slot 3.
- R4: Type code 4, and any code other than 0 or 2, splits a word into two 32-bit slots, slot k being bits [32k+31:32k], and emits slot 0 then slot 1.
- R5: With effective index m, the slot's bits [m:0] are output with bit m on `smp_o[23]`. Lower output bits are zero, and slot bits above m are ignored. When m is above 23, the slot's bits below m-23 are dropped.
- R6: When `chan_mask_i[1]` is 0 (mono), each sample is emitted twice, first with `smp_chan_o`=0 (A) and then with 1 (B).
- R7: When `chan_mask_i[1]` is 1 (stereo), each sample is emitted once. `smp_chan_o` starts at 0 (A) after reset and toggles on every accepted output.
- R8: `word_ready_o` is 0 from the cycle after a word is accepted until its last output is accepted. A word offered meanwhile is not taken, and its data does not appear before then.
- R9: While `smp_valid_o` is 1 and `smp_ready_i` is 0, `smp_o` and `smp_chan_o` hold their values.
- R10: An MSB index above the container width minus one is clamped to the container width minus one (7, 15 or 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_type_i | input | 3 | Container type code |
| msb_pos_i | input | 5 | Sample MSB index (width minus one) |
| chan_mask_i | input | 8 | Channel mask; bit 1 set selects stereo |
| word_i | input | 64 | Packed sample word |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Word accepted when valid |
| smp_o | output | 24 | MSB-aligned sample |
| smp_chan_o | output | 1 | Channel tag, 0 = A, 1 = B |
| smp_valid_o | output | 1 | Sample present |
| smp_ready_i | input | 1 | Sample taken |

## Verification
The assertions rely on `fmt_type_i`, `msb_pos_i` and `chan_mask_i` staying constant while a word is being unpacked. The checks on hold and low-bit zeros relate outputs to those inputs within the same cycle. The bench sets the configuration together with each word and changes it only once `word_ready_o` shows that the previous word has been fully drained. It drives every input at the falling edge, so each input is settled before the edge that samples it.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  typedef enum logic [1:0] {CW8, CW16, CW32} cw_e;

  function automatic cw_e decode_type(input logic [2:0] t);
    case (t)
      3'd0:    return CW8;
      3'd2:    return CW16;
      default: return CW32;
    endcase
  endfunction
endpackage

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
  import unpk_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cw_e              cw_i,
  input  logic             stereo_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             smp_valid_o,
  input  logic             smp_ready_i,
  output logic             chan_o
);
  logic             full_q, rep_q, chan_q;
  logic [IDX_W-1:0] idx_q, last_idx;
  logic             fire;

  always_comb begin
    case (cw_i)
      CW8:     last_idx = IDX_W'(7);
      CW16:    last_idx = IDX_W'(3);
      default: last_idx = IDX_W'(1);
    endcase
  end

  assign word_ready_o = !full_q;
  assign load_o       = word_valid_i && !full_q;
  assign smp_valid_o  = full_q;
  assign fire         = full_q && smp_ready_i;
  assign idx_o        = idx_q;
  assign chan_o       = chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      rep_q  <= 1'b0;
      chan_q <= 1'b0;
      idx_q  <= '0;
    end else if (load_o) begin
      full_q <= 1'b1;
      rep_q  <= 1'b0;
      idx_q  <= '0;
    end else if (fire) begin
      chan_q <= !chan_q;
      if (!stereo_i && !rep_q) begin
        rep_q <= 1'b1;
      end else begin
        rep_q <= 1'b0;
        if (idx_q == last_idx) full_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end
    end
  end

  a_r7_tag_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && smp_ready_i) |=> (chan_o != $past(chan_o)));
  a_r8_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> (smp_valid_o && !word_ready_o));
  a_r6_mono_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && smp_ready_i && !stereo_i && !chan_o) |=> (smp_valid_o && chan_o && $stable(idx_o)));
  a_r2_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> (idx_o <= last_idx));
endmodule

// File: rtl/unpk_slot_sel.sv
module unpk_slot_sel
  import unpk_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic [WORD_W-1:0] word_i,
  input  cw_e               cw_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [31:0]       slot_o
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int N32 = WORD_W / 32;

  logic [7:0]  l8  [N8];
  logic [15:0] l16 [N16];
  logic [31:0] l32 [N32];

  for (genvar g = 0; g < N8; g++)  begin : g_l8  assign l8[g]  = word_i[8*g  +: 8];  end
  for (genvar g = 0; g < N16; g++) begin : g_l16 assign l16[g] = word_i[16*g +: 16]; end
  for (genvar g = 0; g < N32; g++) begin : g_l32 assign l32[g] = word_i[32*g +: 32]; end

  always_comb begin
    slot_o = '0;
    case (cw_i)
      CW8:     for (int i = 0; i < N8; i++)  if (idx_i == IDX_W'(i)) slot_o = {24'd0, l8[i]};
      CW16:    for (int i = 0; i < N16; i++) if (idx_i == IDX_W'(i)) slot_o = {16'd0, l16[i]};
      default: for (int i = 0; i < N32; i++) if (idx_i == IDX_W'(i)) slot_o = l32[i];
    endcase
  end
endmodule

// File: rtl/unpk_align.sv
module unpk_align
  import unpk_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int MSB_W = 5
) (
  input  logic [31:0]      slot_i,
  input  cw_e              cw_i,
  input  logic [MSB_W-1:0] msb_i,
  output logic [OUT_W-1:0] smp_o
);
  localparam logic [MSB_W-1:0] TOP = MSB_W'(OUT_W - 1);

  logic [MSB_W-1:0] cap, m;
  logic [31:0]      keep, sh;

  always_comb begin
    case (cw_i)
      CW8:     cap = MSB_W'(7);
      CW16:    cap = MSB_W'(15);
      default: cap = MSB_W'(31);
    endcase
    m    = (msb_i > cap) ? cap : msb_i;
    keep = slot_i & (32'hFFFF_FFFF >> (MSB_W'(31) - m));
    if (m <= TOP) sh = keep << (TOP - m);
    else          sh = keep >> (m - TOP);
    smp_o = sh[OUT_W-1:0];
  end
endmodule

// File: rtl/sample_unpacker.sv
module sample_unpacker
  import unpk_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 24,
  parameter int MSB_W  = 5,
  parameter int MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_type_i,
  input  logic [MSB_W-1:0]  msb_pos_i,
  input  logic [MASK_W-1:0] chan_mask_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [OUT_W-1:0]  smp_o,
  output logic              smp_chan_o,
  input  logic              smp_ready_i
  ,output logic             smp_valid_o
);
  localparam int IDX_W = $clog2(WORD_W / 8);

  cw_e               cw;
  logic              load;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  logic [31:0]       slot;

  assign cw = decode_type(fmt_type_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (load) word_q <= word_i;
  end

  unpk_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .cw_i(cw), .stereo_i(chan_mask_i[1]),
    .word_valid_i, .word_ready_o, .load_o(load), .idx_o(idx),
    .smp_valid_o, .smp_ready_i, .chan_o(smp_chan_o)
  );

  unpk_slot_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_sel (
    .word_i(word_q), .cw_i(cw), .idx_i(idx), .slot_o(slot)
  );

  unpk_align #(.OUT_W(OUT_W), .MSB_W(MSB_W)) u_align (
    .slot_i(slot), .cw_i(cw), .msb_i(msb_pos_i), .smp_o(smp_o)
  );

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_o) && $stable(smp_chan_o)));
  a_r2_byte_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && fmt_type_i == 3'd0) |-> (smp_o[15:0] == 16'd0));
  a_r5_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && msb_pos_i < 5'd16) |-> (smp_o[7:0] == 8'd0));
  a_r1_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_o |-> word_ready_o);
endmodule

// File: tb/sample_unpacker_test.sv
module sample_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_type = '0;
  logic [4:0]  msb_pos = '0;
  logic [7:0]  chan_mask = '0;
  logic [63:0] word = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [23:0] smp;
  logic        smp_chan;
  logic        smp_valid;
  logic        smp_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_chan = 1'b0;
  bit   done = 1'b0;

  always #10 clk = !clk;

  sample_unpacker uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_type_i(fmt_type), .msb_pos_i(msb_pos),
    .chan_mask_i(chan_mask), .word_i(word), .word_valid_i(word_valid),
    .word_ready_o(word_ready), .smp_o(smp), .smp_chan_o(smp_chan),
    .smp_ready_i(smp_ready), .smp_valid_o(smp_valid)
  );

  // type(3) msb(5) mask(8) word(64)
  localparam logic [79:0] VECS [8] = '{
    {3'd0, 5'd7,  8'h03, 64'h8877_6655_4433_2211},   // R2
    {3'd2, 5'd15, 8'h03, 64'hDEAD_BEEF_1234_5678},   // R3
    {3'd4, 5'd23, 8'h03, 64'h00AB_CDEF_0012_3456},   // R4
    {3'd4, 5'd19, 8'h01, 64'h000F_1234_000A_BCDE},   // R6 mono
    {3'd4, 5'd31, 8'h03, 64'h89AB_CDEF_7654_3210},   // R5 truncation
    {3'd6, 5'd23, 8'h02, 64'h11FF_EEDD_22CC_BBAA},   // R4 unknown code
    {3'd2, 5'd23, 8'h03, 64'h0123_4567_89AB_CDEF},   // R10 clamp
    {3'd0, 5'd5,  8'h01, 64'hFFC3_8142_7E00_A5FF}    // R5/R6 narrow mono
  };

  function automatic logic [23:0] model(input logic [2:0] t, input logic [4:0] msb,
                                        input logic [63:0] w, input int s);
    int cw;
    int m;
    logic [63:0] v;
    cw = (t == 3'd0) ? 8 : (t == 3'd2) ? 16 : 32;
    m  = (int'(msb) > cw - 1) ? cw - 1 : int'(msb);
    v  = (w >> (s * cw)) & ((64'd1 << cw) - 64'd1);
    v  = v & ((64'd1 << (m + 1)) - 64'd1);
    if (m <= 23) v = v << (23 - m);
    else         v = v >> (m - 23);
    return v[23:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [2:0] t, input logic [4:0] m, input logic [7:0] k,
                       input logic [63:0] w);
    fmt_type = t; msb_pos = m; chan_mask = k; word = w;
    word_valid = 1'b1; smp_ready = 1'b1;
    chk("R8 ready before load", 32'(word_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic drain(input logic [2:0] t, input logic [4:0] m, input logic [7:0] k,
                       input logic [63:0] w);
    int slots;
    int outs;
    slots = (t == 3'd0) ? 8 : (t == 3'd2) ? 4 : 2;
    outs  = k[1] ? slots : 2 * slots;
    for (int o = 0; o < outs; o++) begin
      int s;
      s = k[1] ? o : o / 2;
      chk("R2/R3/R4 valid", 32'(smp_valid), 32'd1);
      chk("R2/R3/R4/R5/R10 sample", 32'(smp), 32'(model(t, m, w, s)));
      chk(k[1] ? "R7 tag" : "R6 tag", 32'(smp_chan), 32'(exp_chan));
      chk("R8 busy", 32'(word_ready), 32'd0);
      exp_chan = !exp_chan;
      @(posedge clk); @(negedge clk);
    end
    chk("R8 ready after drain", 32'(word_ready), 32'd1);
    chk("R8 idle after drain", 32'(smp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(smp_valid), 32'd0);
    chk("R1 ready in reset", 32'(word_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(smp_valid), 32'd0);
    chk("R1 ready after reset", 32'(word_ready), 32'd1);

    for (int v = 0; v < 8; v++) begin
      offer(VECS[v][79:77], VECS[v][76:72], VECS[v][71:64], VECS[v][63:0]);
      drain(VECS[v][79:77], VECS[v][76:72], VECS[v][71:64], VECS[v][63:0]);
    end

    // R9: backpressure holds the sample
    offer(3'd2, 5'd15, 8'h03, 64'h0000_0000_4444_ABCD);
    smp_ready = 1'b0;
    chk("R9 first", 32'(smp), 32'hABCD00);
    repeat (3) @(negedge clk);
    chk("R9 held data", 32'(smp), 32'hABCD00);
    chk("R9 held tag", 32'(smp_chan), 32'(exp_chan));
    chk("R9 held valid", 32'(smp_valid), 32'd1);
    smp_ready = 1'b1;
    exp_chan = !exp_chan;
    @(posedge clk); @(negedge clk);
    chk("R9 advance", 32'(smp), 32'h444400);
    exp_chan = !exp_chan;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R8: a word offered while busy is not taken early
    offer(3'd4, 5'd23, 8'h03, 64'h0011_1111_0022_2222);
    word = 64'h0033_3333_0044_4444;
    word_valid = 1'b1;
    chk("R8 first word s0", 32'(smp), 32'h222222);
    chk("R8 busy", 32'(word_ready), 32'd0);
    exp_chan = !exp_chan;
    @(posedge clk); @(negedge clk);
    chk("R8 first word s1", 32'(smp), 32'h111111);
    exp_chan = !exp_chan;
    @(posedge clk); @(negedge clk);
    chk("R8 ready after drain", 32'(word_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    word_valid = 1'b0;
    chk("R8 second word s0", 32'(smp), 32'h444444);
    chk("R7 tag continues", 32'(smp_chan), 32'(exp_chan));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule